// File: doc/BRIEF.md
# Row-Cache Column Read Port

This block is the read side of a one-row SRAM cache placed in front of a DRAM array. It stores one full row of words and a latch holding the row number of the most recent row-strobe read. Reads need no row strobe. A column address picks a word from the stored row, and after a fixed number of clock cycles that word is driven onto the output bus with a valid flag.

Two read modes are chosen by the column strobe. While the strobe is held high (static-column mode), the block follows the column address. Any change restarts the access, and the valid flag drops in the same cycle. While the strobe is pulled low (page mode), the column is captured on the falling edge and later address changes are ignored until the next falling edge. A row-load port fills the row on a read miss and reloads the row latch. The access timer keeps running while the bus is disabled, so reads continue while the array precharges or refreshes.

Top module: `crp_cache_read_port`

## Requirements
- R1: While rst_n is low, valid_o is 0 and dq_o is all zeros.
- R2: dq_oe_o is 1 only when cs_n_i, oe_n_i and wr_inhibit_i are all 0. In any cycle where it is 0, valid_o is 0 and dq_o is all zeros.
- R3: With cstrobe_n_i high, a change of col_i forces valid_o to 0 in that same cycle. valid_o returns to 1 at the ACC_DLY-th rising edge after the first edge that samples the new stable address. dq_o then carries the stored word at that column.
- R4: A rising edge that samples cstrobe_n_i low, after an edge that sampled it high, captures col_i. The captured word becomes valid ACC_DLY edges later. While the strobe stays low, changes of col_i leave valid_o and dq_o unchanged. Raising the strobe again with the same address does not interrupt the read.
- R5: On an edge with lrr_load_i high, lrr_row_o takes lrr_row_i and holds it until the next such edge.
- R6: A fill write (fill_we_i high) to the column being served drops valid_o after that edge. The new word is delivered ACC_DLY edges later. A fill write to any other column leaves valid_o and dq_o unchanged.
- R7: An lrr_load_i pulse restarts the current access: valid_o is 0 after that edge and returns after ACC_DLY edges.
- R8: The access timer advances while the bus is disabled. If the enables return after the delay has elapsed, valid_o and the correct word appear in that cycle with no added wait.
- R9: When a page-mode capture and a fill write to the same column occur on the same edge, the word delivered is the newly written one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n_i | input | 1 | Chip select, active low |
| oe_n_i | input | 1 | Output enable, active low |
| cstrobe_n_i | input | 1 | Column strobe, active low; held high selects static-column mode |
| col_i | input | COL_W (9) | Column address |
| wr_inhibit_i | input | 1 | Write-miss inhibit from the write controller; disables the output |
| fill_we_i | input | 1 | Row-load write strobe |
| fill_col_i | input | COL_W (9) | Column written by the row-load port |
| fill_data_i | input | DATA_W (8) | Word written by the row-load port |
| lrr_load_i | input | 1 | Loads the last-read-row latch (row-strobe read cycle) |
| lrr_row_i | input | ROW_W (11) | Row number to latch |
| dq_o | output | DATA_W (8) | Read data; zero while disabled |
| dq_oe_o | output | 1 | Output drive enable |
| valid_o | output | 1 | Read data valid |
| lrr_row_o | output | ROW_W (11) | Row currently served by the cache |

## Verification
Two functions can land on the same rising edge: a page-mode column capture and a row-load write to that same column. The test lowers the column strobe and pulses the fill write in the same half-cycle, with the fill aimed at the column being captured. It then expects the valid flag to stay low for ACC_DLY edges and the word finally delivered to be the newly written value, not the stale one. A related overlap is also checked: the access delay elapses while the inhibit holds the bus off, and the data must appear in the very cycle the inhibit drops.

// File: rtl/crp_pkg.sv
package crp_pkg;
    localparam int unsigned CRP_COL_W   = 9;
    localparam int unsigned CRP_DATA_W  = 8;
    localparam int unsigned CRP_ROW_W   = 11;
    localparam int unsigned CRP_ACC_DLY = 3;

    typedef enum logic {
        MODE_PAGE   = 1'b0,
        MODE_STATIC = 1'b1
    } rd_mode_e;
endpackage

// File: rtl/crp_row_store.sv
module crp_row_store #(
    parameter int unsigned COL_W  = crp_pkg::CRP_COL_W,
    parameter int unsigned DATA_W = crp_pkg::CRP_DATA_W
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [COL_W-1:0]  wr_col_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [COL_W-1:0]  rd_col_i,
    output logic [DATA_W-1:0] rd_data_o
);
    localparam int unsigned DEPTH = 1 << COL_W;

    logic [DATA_W-1:0] words_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            words_q[wr_col_i] <= wr_data_i;
        end
    end

    assign rd_data_o = words_q[rd_col_i];
endmodule

// File: rtl/crp_access_ctl.sv
module crp_access_ctl
    import crp_pkg::*;
#(
    parameter int unsigned COL_W   = CRP_COL_W,
    parameter int unsigned DATA_W  = CRP_DATA_W,
    parameter int unsigned ACC_DLY = CRP_ACC_DLY
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cstrobe_n_i,
    input  logic [COL_W-1:0]  col_i,
    input  logic              restart_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic [COL_W-1:0]  rd_col_o,
    output logic [DATA_W-1:0] word_o,
    output logic              ready_o,
    output logic              pending_o
);
    localparam int unsigned CNT_W = $clog2(ACC_DLY + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(ACC_DLY);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    typedef struct packed {
        logic [COL_W-1:0]  col;
        logic [CNT_W-1:0]  cnt;
        logic              strobe_prev;
        logic              valid;
        logic [DATA_W-1:0] word;
    } acc_state_t;

    acc_state_t st_d, st_q;
    rd_mode_e   mode;
    logic       strobe_fall;
    logic       addr_moved;

    always_comb begin
        mode        = cstrobe_n_i ? MODE_STATIC : MODE_PAGE;
        strobe_fall = (mode == MODE_PAGE) && st_q.strobe_prev;
        addr_moved  = (mode == MODE_STATIC) && (col_i != st_q.col);

        st_d             = st_q;
        st_d.strobe_prev = cstrobe_n_i;

        if (strobe_fall || addr_moved) begin
            st_d.col   = col_i;
            st_d.cnt   = CNT_LOAD;
            st_d.valid = 1'b0;
        end else if (restart_i) begin
            st_d.cnt   = CNT_LOAD;
            st_d.valid = 1'b0;
        end else if (st_q.cnt == CNT_ONE) begin
            st_d.cnt   = '0;
            st_d.valid = 1'b1;
            st_d.word  = rd_data_i;
        end else if (st_q.cnt != '0) begin
            st_d.cnt   = st_q.cnt - CNT_ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.col         <= '0;
            st_q.cnt         <= CNT_LOAD;
            st_q.strobe_prev <= 1'b1;
            st_q.valid       <= 1'b0;
            st_q.word        <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_col_o  = st_q.col;
    assign word_o    = st_q.word;
    assign ready_o   = st_q.valid;
    assign pending_o = strobe_fall || addr_moved;
endmodule

// File: rtl/crp_cache_read_port.sv
module crp_cache_read_port
    import crp_pkg::*;
#(
    parameter int unsigned COL_W   = CRP_COL_W,
    parameter int unsigned DATA_W  = CRP_DATA_W,
    parameter int unsigned ROW_W   = CRP_ROW_W,
    parameter int unsigned ACC_DLY = CRP_ACC_DLY
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_i,
    input  logic              oe_n_i,
    input  logic              cstrobe_n_i,
    input  logic [COL_W-1:0]  col_i,
    input  logic              wr_inhibit_i,
    input  logic              fill_we_i,
    input  logic [COL_W-1:0]  fill_col_i,
    input  logic [DATA_W-1:0] fill_data_i,
    input  logic              lrr_load_i,
    input  logic [ROW_W-1:0]  lrr_row_i,
    output logic [DATA_W-1:0] dq_o,
    output logic              dq_oe_o,
    output logic              valid_o,
    output logic [ROW_W-1:0]  lrr_row_o
);
    logic [COL_W-1:0]  rd_col;
    logic [DATA_W-1:0] rd_data;
    logic [DATA_W-1:0] word;
    logic              ready;
    logic              pending;
    logic              restart;
    logic              drive_en;
    logic [ROW_W-1:0]  row_d, row_q;

    crp_row_store #(
        .COL_W  (COL_W),
        .DATA_W (DATA_W)
    ) u_store (
        .clk       (clk),
        .we_i      (fill_we_i),
        .wr_col_i  (fill_col_i),
        .wr_data_i (fill_data_i),
        .rd_col_i  (rd_col),
        .rd_data_o (rd_data)
    );

    crp_access_ctl #(
        .COL_W   (COL_W),
        .DATA_W  (DATA_W),
        .ACC_DLY (ACC_DLY)
    ) u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cstrobe_n_i (cstrobe_n_i),
        .col_i       (col_i),
        .restart_i   (restart),
        .rd_data_i   (rd_data),
        .rd_col_o    (rd_col),
        .word_o      (word),
        .ready_o     (ready),
        .pending_o   (pending)
    );

    always_comb begin
        restart  = lrr_load_i || (fill_we_i && (fill_col_i == rd_col));
        row_d    = lrr_load_i ? lrr_row_i : row_q;
        drive_en = !cs_n_i && !oe_n_i && !wr_inhibit_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
        end else begin
            row_q <= row_d;
        end
    end

    assign dq_oe_o   = drive_en;
    assign valid_o   = drive_en && ready && !pending;
    assign dq_o      = drive_en ? word : '0;
    assign lrr_row_o = row_q;
endmodule

// File: rtl/crp_checker.sv
module crp_checker #(
    parameter int unsigned COL_W  = 9,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ROW_W  = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n_i,
    input logic              oe_n_i,
    input logic              cstrobe_n_i,
    input logic [COL_W-1:0]  col_i,
    input logic              wr_inhibit_i,
    input logic              lrr_load_i,
    input logic [ROW_W-1:0]  lrr_row_i,
    input logic [DATA_W-1:0] dq_o,
    input logic              dq_oe_o,
    input logic              valid_o,
    input logic [ROW_W-1:0]  lrr_row_o
);
    assert_bus_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n_i || oe_n_i || wr_inhibit_i) |-> (!dq_oe_o && !valid_o && dq_o == '0));

    assert_static_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && cstrobe_n_i && $past(cstrobe_n_i) && col_i != $past(col_i))
        |-> !valid_o);

    assert_word_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && $past(valid_o)) |-> $stable(dq_o));

    assert_row_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(lrr_load_i)) |-> (lrr_row_o == $past(lrr_row_i)));

    assert_row_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(lrr_load_i)) |-> !valid_o);
endmodule

bind crp_cache_read_port crp_checker #(
    .COL_W  (COL_W),
    .DATA_W (DATA_W),
    .ROW_W  (ROW_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs_n_i       (cs_n_i),
    .oe_n_i       (oe_n_i),
    .cstrobe_n_i  (cstrobe_n_i),
    .col_i        (col_i),
    .wr_inhibit_i (wr_inhibit_i),
    .lrr_load_i   (lrr_load_i),
    .lrr_row_i    (lrr_row_i),
    .dq_o         (dq_o),
    .dq_oe_o      (dq_oe_o),
    .valid_o      (valid_o),
    .lrr_row_o    (lrr_row_o)
);

// File: tb/sim_crp_cache_read_port.sv
module sim_crp_cache_read_port;
    localparam int unsigned COL_W   = 9;
    localparam int unsigned DATA_W  = 8;
    localparam int unsigned ROW_W   = 11;
    localparam int unsigned ACC_DLY = 3;
    localparam int unsigned DEPTH   = 1 << COL_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cs_n_i = 1'b0;
    logic              oe_n_i = 1'b0;
    logic              cstrobe_n_i = 1'b1;
    logic [COL_W-1:0]  col_i = '0;
    logic              wr_inhibit_i = 1'b0;
    logic              fill_we_i = 1'b0;
    logic [COL_W-1:0]  fill_col_i = '0;
    logic [DATA_W-1:0] fill_data_i = '0;
    logic              lrr_load_i = 1'b0;
    logic [ROW_W-1:0]  lrr_row_i = '0;
    logic [DATA_W-1:0] dq_o;
    logic              dq_oe_o;
    logic              valid_o;
    logic [ROW_W-1:0]  lrr_row_o;

    logic [DATA_W-1:0] exp_mem [DEPTH];
    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    crp_cache_read_port #(
        .COL_W(COL_W), .DATA_W(DATA_W), .ROW_W(ROW_W), .ACC_DLY(ACC_DLY)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n_i), .oe_n_i(oe_n_i),
        .cstrobe_n_i(cstrobe_n_i), .col_i(col_i), .wr_inhibit_i(wr_inhibit_i),
        .fill_we_i(fill_we_i), .fill_col_i(fill_col_i), .fill_data_i(fill_data_i),
        .lrr_load_i(lrr_load_i), .lrr_row_i(lrr_row_i),
        .dq_o(dq_o), .dq_oe_o(dq_oe_o), .valid_o(valid_o), .lrr_row_o(lrr_row_o)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // counts edges from the drive point; pulses are cleared after the first edge
    task automatic wait_access(input string req, input logic [DATA_W-1:0] exp_word);
        for (int i = 0; i < int'(ACC_DLY); i++) begin
            @(posedge clk); #1;
            fill_we_i  = 1'b0;
            lrr_load_i = 1'b0;
        end
        chk(!valid_o, req, 32'(valid_o), 32'd0);
        @(posedge clk); #1;
        chk(valid_o, req, 32'(valid_o), 32'd1);
        chk(dq_o == exp_word, req, 32'(dq_o), 32'(exp_word));
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        #1;
        chk(!valid_o, "R1", 32'(valid_o), 32'd0);
        chk(dq_o == '0, "R1", 32'(dq_o), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int c = 0; c < int'(DEPTH); c++) begin
            @(negedge clk);
            fill_we_i   = 1'b1;
            fill_col_i  = COL_W'(c);
            fill_data_i = DATA_W'(c * 37 + 11);
            exp_mem[c]  = DATA_W'(c * 37 + 11);
        end
        @(negedge clk);
        fill_we_i = 1'b0;
    endtask

    task automatic t_static();
        int cols [3] = '{5, 511, 256};
        foreach (cols[k]) begin
            @(negedge clk);
            col_i = COL_W'(cols[k]);
            #1;
            chk(!valid_o, "R3", 32'(valid_o), 32'd0);
            wait_access("R3", exp_mem[cols[k]]);
        end
    endtask

    task automatic t_page();
        logic [DATA_W-1:0] held;
        @(negedge clk);
        cstrobe_n_i = 1'b0;
        col_i = 9'h1A3;
        wait_access("R4", exp_mem[9'h1A3]);
        held = dq_o;
        @(negedge clk);
        col_i = 9'h055;
        repeat (ACC_DLY + 2) @(posedge clk);
        #1;
        chk(valid_o && dq_o == held, "R4", 32'(dq_o), 32'(held));
        @(negedge clk);
        col_i = 9'h1A3;
        @(negedge clk);
        cstrobe_n_i = 1'b1;
        @(posedge clk); #1;
        chk(valid_o, "R4", 32'(valid_o), 32'd1);
        @(negedge clk);
        cstrobe_n_i = 1'b0;
        col_i = 9'h0F0;
        wait_access("R4", exp_mem[9'h0F0]);
        @(negedge clk);
        cstrobe_n_i = 1'b1;
    endtask

    task automatic t_gating();
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            cs_n_i       = (k == 0);
            oe_n_i       = (k == 1);
            wr_inhibit_i = (k == 2);
            #1;
            chk(!valid_o && !dq_oe_o && dq_o == '0, "R2", 32'(dq_o), 32'd0);
            @(negedge clk);
            cs_n_i = 1'b0; oe_n_i = 1'b0; wr_inhibit_i = 1'b0;
            #1;
            chk(valid_o && dq_o == exp_mem[9'h0F0], "R2", 32'(dq_o), 32'(exp_mem[9'h0F0]));
        end
    endtask

    task automatic t_background();
        @(negedge clk);
        wr_inhibit_i = 1'b1;
        col_i = 9'h033;
        repeat (ACC_DLY + 2) @(posedge clk);
        @(negedge clk);
        wr_inhibit_i = 1'b0;
        #1;
        chk(valid_o && dq_o == exp_mem[9'h033], "R8", 32'(dq_o), 32'(exp_mem[9'h033]));
    endtask

    task automatic t_fill();
        @(negedge clk);
        fill_we_i = 1'b1; fill_col_i = 9'h034; fill_data_i = 8'hC3;
        exp_mem[9'h034] = 8'hC3;
        @(negedge clk);
        fill_we_i = 1'b0;
        #1;
        chk(valid_o && dq_o == exp_mem[9'h033], "R6", 32'(dq_o), 32'(exp_mem[9'h033]));
        @(negedge clk);
        fill_we_i = 1'b1; fill_col_i = 9'h033; fill_data_i = 8'h5A;
        exp_mem[9'h033] = 8'h5A;
        wait_access("R6", 8'h5A);
    endtask

    task automatic t_lrr();
        @(negedge clk);
        lrr_load_i = 1'b1;
        lrr_row_i  = 11'h2A5;
        wait_access("R7", exp_mem[9'h033]);
        chk(lrr_row_o == 11'h2A5, "R5", 32'(lrr_row_o), 32'h2A5);
        @(negedge clk);
        lrr_row_i = 11'h013;
        repeat (2) @(posedge clk);
        #1;
        chk(lrr_row_o == 11'h2A5, "R5", 32'(lrr_row_o), 32'h2A5);
    endtask

    task automatic t_concurrent();
        @(negedge clk);
        cstrobe_n_i = 1'b0;
        col_i = 9'h140;
        fill_we_i = 1'b1; fill_col_i = 9'h140; fill_data_i = 8'hE7;
        exp_mem[9'h140] = 8'hE7;
        wait_access("R9", 8'hE7);
        @(negedge clk);
        cstrobe_n_i = 1'b1;
    endtask

    initial begin
        t_reset();
        t_static();
        t_page();
        t_gating();
        t_background();
        t_fill();
        t_lrr();
        t_concurrent();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule